// File: doc/BRIEF.md
# Half-Duplex Scalable-Width Link Slave

This block is the slave end of a half-duplex link. The master supplies the clock, an active-low select and a shared data bus of up to eight wires, and the slave owns a separate status wire (MISO). Each time the slave is selected it first shifts in a command byte that gives the transfer direction and the lane count (1, 2, 4 or 8). It then moves whole bytes between the bus and local byte FIFO ports. For a write, bytes go from the bus into the receive FIFO. For a read, bytes go from the transmit FIFO onto the bus. For each byte the slave reports ACK or NAK on MISO.

While it is deselected the slave can show buffer status on data wire 0 and on MISO. An enable input turns this off, so that several slaves can share the wires. Read transfers put one idle turnaround clock between the command and the slave driving the bus. A NAK stops all further transfer until the master releases select. Releasing select at any point returns the slave to idle and discards any byte that was only partly shifted.

The block samples inputs on the rising clock edge and changes the data, enable and MISO registers on the falling edge. The tristate pads sit outside the block, driven by the output and output-enable pins.

Top module: `hdx_link_slave`

## Requirements
- R1: While sel_n is high and status_en is 1, bus_oe is 8'h01, bus_out[0] equals rx_full (0 = write space available), miso_oe is 1 and miso equals tx_empty (0 = read data available).
- R2: While sel_n is high and status_en is 0, bus_oe is 8'h00 and miso_oe is 0, from reset onward.
- R3: After select falls, the first 8 rising edges shift a command in on bus_in[0], least significant bit first. Bit 0 is the direction (1 = read, 0 = write). Bits [2:1] give the width code: 00 = 1 lane, 01 = 2, 10 = 4, 11 = 8. Bits [7:3] are ignored.
- R4: In a write, each byte takes 8/W rising edges on lanes bus_in[W-1:0], lowest lane group first. When the last group arrives and rx_full is 0, rx_push pulses for that cycle with the assembled byte on rx_data.
- R5: A write byte that completes while rx_full is 1 is NAKed. It is not pushed, and no push or pop follows until select is released.
- R6: In a read, the clock after the command is a turnaround: bus_oe stays 8'h00 through it, and the slave drives the first lane group from the falling edge after it.
- R7: A read byte is popped from the transmit FIFO (tx_pop with tx_empty 0) when the command completes and at the end of each previous byte. It is sent lowest lane group first, with bus_oe equal to the lane mask of the selected width.
- R8: A read byte whose fetch finds tx_empty at 1 is NAKed. There is no pop, miso goes high and bus_oe stays 8'h00 until deselect.
- R9: While selected, miso_oe is 1 and miso carries the latest byte result, changed on the falling edge: 0 = ACK, 1 = NAK. It is 0 before the first result.
- R10: Raising sel_n at any point returns the slave to idle. A partly shifted write byte is never pushed, and the next selection starts with a new command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sclk | input | 1 | Master-driven link clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Active-low slave select |
| status_en | input | 1 | Enables idle buffer status on data wire 0 and MISO |
| bus_in | input | 8 | Sampled value of the shared data wires |
| bus_out | output | 8 | Value the slave drives onto the data wires |
| bus_oe | output | 8 | Per-wire output enable for the data pads |
| miso | output | 1 | Status/ACK-NAK value for the MISO wire |
| miso_oe | output | 1 | Output enable for the MISO pad |
| tx_empty | input | 1 | Transmit FIFO has no byte |
| tx_data | input | 8 | Byte at the head of the transmit FIFO |
| tx_pop | output | 1 | Removes the head byte from the transmit FIFO |
| rx_full | input | 1 | Receive FIFO cannot take a byte |
| rx_data | output | 8 | Byte to write into the receive FIFO |
| rx_push | output | 1 | Writes rx_data into the receive FIFO |

## Verification
The hardest condition to reach is a NAK in the middle of a read burst. It happens only when the transmit FIFO runs dry exactly on a byte boundary while the master is still clocking lanes. The bench gets there by loading the transmit model with fewer bytes than a read burst asks for, so that the fetch for the next byte finds the FIFO empty. It then checks that miso rises and bus_oe falls at that falling edge. A write abort is staged the same way: select is released a few beats into a byte, and the bench checks that no push arrives and that the next command decodes from its first bit.

// File: rtl/hdx_link_pkg.sv
package hdx_link_pkg;

  localparam int BYTE_W = 8;

  typedef logic [1:0] width_code_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_TURN,
    ST_WDATA,
    ST_RDATA,
    ST_HOLD
  } link_state_e;

  // number of clock beats per byte for a width code
  function automatic logic [3:0] beats_of(width_code_t c);
    return 4'(BYTE_W >> c);
  endfunction

  // enable pattern of the active lanes
  function automatic logic [BYTE_W-1:0] lane_mask(width_code_t c);
    case (c)
      2'd0:    return 8'h01;
      2'd1:    return 8'h03;
      2'd2:    return 8'h0F;
      default: return 8'hFF;
    endcase
  endfunction

  // receive assembly: new lanes enter at the top, byte drifts toward bit 0
  function automatic logic [BYTE_W-1:0] rx_shift(logic [BYTE_W-1:0] sh,
                                                 logic [BYTE_W-1:0] din,
                                                 width_code_t c);
    case (c)
      2'd0:    return {din[0],   sh[7:1]};
      2'd1:    return {din[1:0], sh[7:2]};
      2'd2:    return {din[3:0], sh[7:4]};
      default: return din;
    endcase
  endfunction

  // transmit advance: drop the lane group just sent
  function automatic logic [BYTE_W-1:0] tx_shift(logic [BYTE_W-1:0] sh,
                                                 width_code_t c);
    case (c)
      2'd0:    return {1'b0, sh[7:1]};
      2'd1:    return {2'b0, sh[7:2]};
      2'd2:    return {4'b0, sh[7:4]};
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/hdx_link_cmd.sv
module hdx_link_cmd
  import hdx_link_pkg::*;
#(
  parameter int CMD_W = 8
) (
  input  logic        sclk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        shift_en,
  input  logic        bit_in,
  output logic        cmd_done,
  output logic        cmd_rd,
  output width_code_t cmd_width
);
  localparam int CNT_W = $clog2(CMD_W);

  logic [CMD_W-2:0] sh;
  logic [CNT_W-1:0] cnt;
  logic [CMD_W-1:0] word;

  // full command as it stands once this bit is taken
  assign word      = {bit_in, sh};
  assign cmd_done  = shift_en && (cnt == CNT_W'(CMD_W - 1));
  assign cmd_rd    = word[0];
  assign cmd_width = word[2:1];

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      sh  <= '0;
      cnt <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (shift_en) begin
      sh  <= word[CMD_W-1:1];
      cnt <= cmd_done ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/hdx_link_lanes.sv
module hdx_link_lanes
  import hdx_link_pkg::*;
(
  input  logic              sclk,
  input  logic              rst_n,
  input  width_code_t       code,
  input  logic              rx_en,
  input  logic [BYTE_W-1:0] din,
  output logic [BYTE_W-1:0] rx_next,
  input  logic              tx_load,
  input  logic              tx_adv,
  input  logic [BYTE_W-1:0] tx_byte,
  output logic [BYTE_W-1:0] tx_lane
);
  logic [BYTE_W-1:0] rx_sh;
  logic [BYTE_W-1:0] tx_sh;

  assign rx_next = rx_shift(rx_sh, din, code);
  assign tx_lane = tx_sh & lane_mask(code);

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      rx_sh <= '0;
      tx_sh <= '0;
    end else begin
      if (rx_en)   rx_sh <= rx_next;
      if (tx_load)     tx_sh <= tx_byte;
      else if (tx_adv) tx_sh <= tx_shift(tx_sh, code);
    end
  end
endmodule

// File: rtl/hdx_link_pad.sv
module hdx_link_pad
  import hdx_link_pkg::*;
(
  input  logic              sclk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              status_en,
  input  logic              rx_full,
  input  logic              tx_empty,
  input  logic              drive_rd,
  input  logic [BYTE_W-1:0] lane,
  input  logic [BYTE_W-1:0] mask,
  input  logic              miso_val,
  output logic [BYTE_W-1:0] bus_out,
  output logic [BYTE_W-1:0] bus_oe,
  output logic              miso,
  output logic              miso_oe
);
  logic [BYTE_W-1:0] drv_d;
  logic [BYTE_W-1:0] drv_oe;
  logic              miso_q;

  // slave-driven values move on the falling edge
  always_ff @(negedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      drv_d  <= '0;
      drv_oe <= '0;
      miso_q <= 1'b0;
    end else begin
      drv_d  <= drive_rd ? lane : '0;
      drv_oe <= drive_rd ? mask : '0;
      miso_q <= miso_val;
    end
  end

  // deselected: optional buffer status, otherwise released wires
  assign bus_out = sel_n ? {{(BYTE_W-1){1'b0}}, rx_full}   : drv_d;
  assign bus_oe  = sel_n ? {{(BYTE_W-1){1'b0}}, status_en} : drv_oe;
  assign miso    = sel_n ? tx_empty  : miso_q;
  assign miso_oe = sel_n ? status_en : 1'b1;
endmodule

// File: rtl/hdx_link_slave.sv
module hdx_link_slave
  import hdx_link_pkg::*;
#(
  parameter int CMD_W = 8
) (
  input  logic       sclk,
  input  logic       rst_n,
  input  logic       sel_n,
  input  logic       status_en,
  input  logic [7:0] bus_in,
  output logic [7:0] bus_out,
  output logic [7:0] bus_oe,
  output logic       miso,
  output logic       miso_oe,
  input  logic       tx_empty,
  input  logic [7:0] tx_data,
  output logic       tx_pop,
  input  logic       rx_full,
  output logic [7:0] rx_data,
  output logic       rx_push
);
  link_state_e state;
  width_code_t width_q;
  logic [3:0]  beat;
  logic        nak_q;

  logic        sel;
  logic        cmd_en, cmd_done, cmd_rd;
  width_code_t cmd_width;
  logic        beat_last;
  logic        cmd_rd_evt, rd_end_evt, fetch_evt, wend_evt, nak_evt;
  logic [7:0]  tx_lane;

  assign sel        = ~sel_n;
  assign cmd_en     = sel && (state == ST_IDLE || state == ST_CMD);
  assign beat_last  = (beat == beats_of(width_q) - 4'd1);

  // named events for the checker
  assign cmd_rd_evt = sel && state == ST_CMD && cmd_done && cmd_rd;
  assign rd_end_evt = sel && state == ST_RDATA && beat_last;
  assign fetch_evt  = cmd_rd_evt || rd_end_evt;
  assign wend_evt   = sel && state == ST_WDATA && beat_last;
  assign nak_evt    = (fetch_evt && tx_empty) || (wend_evt && rx_full);

  assign tx_pop     = fetch_evt && !tx_empty;
  assign rx_push    = wend_evt && !rx_full;

  hdx_link_cmd #(.CMD_W(CMD_W)) u_cmd (
    .sclk     (sclk),
    .rst_n    (rst_n),
    .clr      (sel_n),
    .shift_en (cmd_en),
    .bit_in   (bus_in[0]),
    .cmd_done (cmd_done),
    .cmd_rd   (cmd_rd),
    .cmd_width(cmd_width)
  );

  hdx_link_lanes u_lanes (
    .sclk   (sclk),
    .rst_n  (rst_n),
    .code   (width_q),
    .rx_en  (sel && state == ST_WDATA),
    .din    (bus_in),
    .rx_next(rx_data),
    .tx_load(tx_pop),
    .tx_adv (sel && state == ST_RDATA && !beat_last),
    .tx_byte(tx_data),
    .tx_lane(tx_lane)
  );

  hdx_link_pad u_pad (
    .sclk     (sclk),
    .rst_n    (rst_n),
    .sel_n    (sel_n),
    .status_en(status_en),
    .rx_full  (rx_full),
    .tx_empty (tx_empty),
    .drive_rd (state == ST_RDATA),
    .lane     (tx_lane),
    .mask     (lane_mask(width_q)),
    .miso_val ((state == ST_IDLE) ? 1'b0 : nak_q),
    .bus_out  (bus_out),
    .bus_oe   (bus_oe),
    .miso     (miso),
    .miso_oe  (miso_oe)
  );

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      width_q <= '0;
      beat    <= '0;
      nak_q   <= 1'b0;
    end else if (sel_n) begin
      state <= ST_IDLE;
      beat  <= '0;
      nak_q <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: state <= ST_CMD;
        ST_CMD: begin
          if (cmd_done) begin
            width_q <= cmd_width;
            beat    <= '0;
            nak_q   <= cmd_rd && tx_empty;
            if (!cmd_rd)       state <= ST_WDATA;
            else if (tx_empty) state <= ST_HOLD;
            else               state <= ST_TURN;
          end
        end
        ST_TURN: begin
          state <= ST_RDATA;
          beat  <= '0;
        end
        ST_RDATA: begin
          if (beat_last) begin
            beat <= '0;
            if (tx_empty) begin
              nak_q <= 1'b1;
              state <= ST_HOLD;
            end
          end else begin
            beat <= beat + 4'd1;
          end
        end
        ST_WDATA: begin
          if (beat_last) begin
            beat <= '0;
            if (rx_full) begin
              nak_q <= 1'b1;
              state <= ST_HOLD;
            end
          end else begin
            beat <= beat + 4'd1;
          end
        end
        ST_HOLD: state <= ST_HOLD;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hdx_link_chk.sv
module hdx_link_chk (
  input logic       sclk,
  input logic       rst_n,
  input logic       sel_n,
  input logic       status_en,
  input logic [7:0] bus_out,
  input logic [7:0] bus_oe,
  input logic       miso,
  input logic       miso_oe,
  input logic       tx_empty,
  input logic       tx_pop,
  input logic       rx_full,
  input logic       rx_push,
  input logic       cmd_rd_evt,
  input logic       nak_evt
);
  // R1
  idle_status_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    (sel_n && status_en) |->
      (bus_oe == 8'h01 && bus_out[0] == rx_full && miso_oe && miso == tx_empty));

  // R2
  idle_quiet_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    (sel_n && !status_en) |-> (bus_oe == 8'h00 && !miso_oe));

  // R4
  push_space_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    rx_push |-> !rx_full);

  // R8
  pop_data_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    tx_pop |-> !tx_empty);

  // R5
  nak_freeze_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    nak_evt |=> (!rx_push && !tx_pop));

  // R6
  turnaround_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    cmd_rd_evt |=> (sel_n || bus_oe == 8'h00));

  // R9
  miso_owned_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    !sel_n |-> miso_oe);
endmodule

bind hdx_link_slave hdx_link_chk u_chk (
  .sclk      (sclk),
  .rst_n     (rst_n),
  .sel_n     (sel_n),
  .status_en (status_en),
  .bus_out   (bus_out),
  .bus_oe    (bus_oe),
  .miso      (miso),
  .miso_oe   (miso_oe),
  .tx_empty  (tx_empty),
  .tx_pop    (tx_pop),
  .rx_full   (rx_full),
  .rx_push   (rx_push),
  .cmd_rd_evt(cmd_rd_evt),
  .nak_evt   (nak_evt)
);

// File: tb/hdx_link_slave_bench.sv
`timescale 1ns/100ps
module hdx_link_slave_bench;
  logic       sclk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel_n = 1'b1;
  logic       status_en = 1'b0;
  logic [7:0] bus_in = 8'h00;
  logic [7:0] bus_out, bus_oe, rx_data, tx_data;
  logic       miso, miso_oe, tx_pop, rx_push, tx_empty;
  logic       rx_full = 1'b0;

  int checks = 0;
  int errors = 0;
  int push_cnt = 0;
  bit pop_pending = 0;

  logic [7:0] tx_q[$];
  logic [7:0] exp_rx[$];
  logic [7:0] exp_rd[$];

  hdx_link_slave u_hdx_link_slave (
    .sclk(sclk), .rst_n(rst_n), .sel_n(sel_n), .status_en(status_en),
    .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
    .miso(miso), .miso_oe(miso_oe),
    .tx_empty(tx_empty), .tx_data(tx_data), .tx_pop(tx_pop),
    .rx_full(rx_full), .rx_data(rx_data), .rx_push(rx_push)
  );

  always #2 sclk = ~sclk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic refresh_tx();
    tx_empty = (tx_q.size() == 0);
    tx_data  = tx_empty ? 8'h00 : tx_q[0];
  endtask

  task automatic load_tx(input logic [7:0] b);
    tx_q.push_back(b);
    exp_rd.push_back(b);
    refresh_tx();
  endtask

  // one master clock: drive on the falling edge, settle
  task automatic cyc(input logic s, input logic [7:0] d);
    @(negedge sclk);
    sel_n  = s;
    bus_in = d;
    #1;
  endtask

  task automatic send_cmd(input logic [7:0] c);
    for (int i = 0; i < 8; i++) begin
      cyc(1'b0, {7'b0, c[i]});
      if (i == 3) begin
        chk(miso_oe == 1'b1 && miso == 1'b0, "R9 miso during command", {miso_oe, miso}, 2);
      end
    end
  endtask

  // monitor: compares pushes with the scoreboard, notes pops
  always @(negedge sclk) begin
    #1.5;
    if (rx_push) begin
      push_cnt++;
      if (exp_rx.size() == 0) begin
        chk(1'b0, "R4/R10 unexpected push", rx_data, 0);
      end else begin
        logic [7:0] e;
        e = exp_rx.pop_front();
        chk(rx_data == e, "R4 pushed byte", rx_data, e);
      end
    end
    if (tx_pop) pop_pending = 1;
  end

  always @(posedge sclk) begin
    #0.5;
    if (pop_pending) begin
      pop_pending = 0;
      if (tx_q.size() != 0) void'(tx_q.pop_front());
      refresh_tx();
    end
  end

  task automatic wr_txn(input logic [1:0] code, input logic [4:0] hi,
                        input int n, input logic [31:0] data);
    int w;
    int beats;
    logic [7:0] m;
    bit full;
    w = 1 << code;
    beats = 8 >> code;
    m = 8'((1 << w) - 1);
    full = rx_full;
    send_cmd({hi, code, 1'b0});
    for (int k = 0; k < n; k++) begin
      logic [7:0] b;
      b = data[8*k +: 8];
      if (!full) exp_rx.push_back(b);
      for (int j = 0; j < beats; j++) begin
        cyc(1'b0, 8'(b >> (j * w)) & m);
        if (j == 0 && k > 0) begin
          chk(miso == full, "R9/R5 write result on miso", miso, full);
        end
      end
    end
    if (code != 2'd3) begin
      cyc(1'b0, 8'h00);
      chk(miso == full, "R9/R5 last write result", miso, full);
    end
    cyc(1'b1, 8'h00);
    chk(exp_rx.size() == 0, "R4 all accepted bytes pushed", exp_rx.size(), 0);
  endtask

  task automatic rd_txn(input logic [1:0] code, input logic [4:0] hi, input int n);
    int w;
    int beats;
    int avail;
    logic [7:0] m;
    w = 1 << code;
    beats = 8 >> code;
    m = 8'((1 << w) - 1);
    avail = tx_q.size();
    send_cmd({hi, code, 1'b1});
    cyc(1'b0, 8'h00);
    chk(bus_oe == 8'h00, "R6 turnaround leaves bus released", bus_oe, 0);
    chk(miso == (avail == 0), "R9 first read result", miso, (avail == 0));
    for (int k = 0; k < n; k++) begin
      if (k >= avail) begin
        cyc(1'b0, 8'h00);
        chk(miso == 1'b1, "R8 NAK on empty fetch", miso, 1);
        chk(bus_oe == 8'h00, "R8 no drive after NAK", bus_oe, 0);
        break;
      end else begin
        logic [7:0] got;
        logic [7:0] e;
        got = 8'h00;
        for (int j = 0; j < beats; j++) begin
          cyc(1'b0, 8'h00);
          chk(bus_oe == m, "R7 lane enables", bus_oe, m);
          if (j == 0) chk(miso == 1'b0, "R9 read ACK", miso, 0);
          got = got | 8'((bus_out & m) << (j * w));
        end
        e = exp_rd.pop_front();
        chk(got == e, "R7 read byte", got, e);
      end
    end
    cyc(1'b1, 8'h00);
  endtask

  initial begin
    #800000;
    chk(1'b0, "watchdog expired", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int pc;
    refresh_tx();
    repeat (3) @(negedge sclk);
    #1;
    chk(bus_oe == 8'h00 && miso_oe == 1'b0, "R2 released in reset", {bus_oe, miso_oe}, 0);
    chk(rx_push == 1'b0 && tx_pop == 1'b0, "R10 no FIFO strobes in reset", {rx_push, tx_pop}, 0);
    rst_n = 1'b1;
    cyc(1'b1, 8'h00);
    chk(bus_oe == 8'h00 && miso_oe == 1'b0, "R2 released after reset", {bus_oe, miso_oe}, 0);

    // idle buffer status
    status_en = 1'b1;
    cyc(1'b1, 8'h00);
    chk(bus_oe == 8'h01 && miso_oe == 1'b1, "R1 status enables", {bus_oe, miso_oe}, 9'h3);
    chk(bus_out[0] == 1'b0 && miso == 1'b1, "R1 space free, no data", {bus_out[0], miso}, 1);
    rx_full = 1'b1;
    load_tx(8'hC3);
    cyc(1'b1, 8'h00);
    chk(bus_out[0] == 1'b1 && miso == 1'b0, "R1 full, data present", {bus_out[0], miso}, 2);
    rx_full = 1'b0;

    // writes at every width, upper command bits set (R3)
    wr_txn(2'd0, 5'h1F, 2, 32'h0000_3CA5);
    wr_txn(2'd1, 5'h0A, 2, 32'h0000_E187);
    wr_txn(2'd2, 5'h15, 3, 32'h0096_4B2D);
    wr_txn(2'd3, 5'h11, 3, 32'h00F0_0FAA);

    // write NAK (R5)
    rx_full = 1'b1;
    pc = push_cnt;
    wr_txn(2'd3, 5'h00, 2, 32'h0000_5566);
    wr_txn(2'd0, 5'h03, 1, 32'h0000_0077);
    chk(push_cnt == pc, "R5 no push after NAK", push_cnt, pc);
    rx_full = 1'b0;

    // abort mid-byte (R10)
    pc = push_cnt;
    send_cmd(8'h00);
    cyc(1'b0, 8'h01);
    cyc(1'b0, 8'h01);
    cyc(1'b0, 8'h00);
    cyc(1'b1, 8'h00);
    cyc(1'b1, 8'h00);
    chk(push_cnt == pc, "R10 partial byte discarded", push_cnt, pc);
    wr_txn(2'd1, 5'h07, 1, 32'h0000_00D2);
    chk(push_cnt == pc + 1, "R10 fresh command after abort", push_cnt, pc + 1);

    // reads at every width (R6, R7)
    load_tx(8'h5A);
    rd_txn(2'd0, 5'h15, 2);
    load_tx(8'h12); load_tx(8'hB7); load_tx(8'h6E);
    rd_txn(2'd1, 5'h08, 3);
    load_tx(8'h9C); load_tx(8'h41);
    rd_txn(2'd2, 5'h1E, 2);
    load_tx(8'h03); load_tx(8'hFE); load_tx(8'h80); load_tx(8'h7F);
    rd_txn(2'd3, 5'h01, 4);

    // read NAK: empty at command, then dry mid-burst (R8)
    rd_txn(2'd1, 5'h00, 1);
    load_tx(8'hA9);
    rd_txn(2'd2, 5'h04, 3);
    chk(tx_q.size() == 0, "R8 no pop beyond data", tx_q.size(), 0);

    // status switched off again (R2)
    status_en = 1'b0;
    cyc(1'b1, 8'h00);
    chk(bus_oe == 8'h00 && miso_oe == 1'b0, "R2 released when disabled", {bus_oe, miso_oe}, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule